// File: doc/BRIEF.md
# Descriptor-Driven ADC Conversion Sequencer

This block decides, clock by clock, when a fast analog converter takes a sample and on which channel. It holds two tables of eight programmable 32-bit descriptors. A timer runs on the converter clock. The active descriptor's match value is compared with the timer, and when they agree a one-cycle conversion strobe is issued with the descriptor's channel. The descriptor then decides three things: whether the timer restarts from zero, whether the next entry is the following one or the first one of the table, and whether the sequencer moves over to the other table.

Software programs descriptors and a start selection (table and entry) through a simple write port. A one-cycle trigger then starts the sequencer. A descriptor with match 0, reset-timer set and a branch back to entry 0 samples on every clock. That full-rate loop must not be the entry that starts the run. A start on a match-0 entry is refused, and a latched error flag is raised.

The conversion strobe is a per-cycle valid with no ready. The converter cannot stall, so the channel output counts as valid only in the cycle that `conv_valid` is high, and a consumer has no means of applying back-pressure.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the sequencer is idle: `run_active`, `conv_valid` and `desc_err` are 0. While idle the descriptor timer is held at zero and no strobe is issued, whatever is programmed.
- R2: A trigger that is accepted on a clock edge starts the timer at 0 in the following cycle. The strobe appears one cycle after the cycle in which the timer equals the match field (bits 21:8). A match value M therefore gives the first strobe M+1 cycles after the start edge, and `conv_chan` carries bits 2:0 of the descriptor.
- R3: When bit 24 (reset-timer) of the firing descriptor is set, the timer restarts at 0. When it is clear, the timer keeps counting upward.
- R4: The branch field, bits 7:6, selects the next entry. Value 0 selects the following entry, and entry 7 wraps to entry 0. Value 1 selects entry 0 of the table.
- R5: Bit 31 set in a firing descriptor moves the sequencer to the other table. The branch field picks the entry within that table.
- R6: A descriptor with match 0, reset-timer set and branch 1 produces a strobe on every clock once it is reached.
- R7: A trigger whose selected starting descriptor has match 0 does not start the sequencer and sets `desc_err`.
- R8: A firing descriptor with branch value 2 or 3 still issues its strobe. It also sets `desc_err` and returns the sequencer to idle.
- R9: `desc_err` stays set until a write to the clear address (address 17 by default) with data bit 0 equal to 1. A write there with bit 0 equal to 0 leaves it set.
- R10: The threshold field, bits 23:22, has no effect on strobe timing or sequencing.
- R11: `cur_table` and `cur_index` report the descriptor that is currently active.
- R12: Addresses 0–15 write descriptors (address bit 3 selects the table, bits 2:0 the entry). Address 16 writes the start selection (data bit 3 selects the table, bits 2:0 the entry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ENTRY_W+2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| sw_trig | input | 1 | One-cycle start pulse |
| conv_valid | output | 1 | Conversion strobe |
| conv_chan | output | 3 | Channel for the strobe |
| run_active | output | 1 | Sequencer running |
| cur_table | output | 1 | Active table |
| cur_index | output | ENTRY_W | Active entry |
| desc_err | output | 1 | Latched descriptor error |

## Verification
The hardest state to reach is the full-rate loop. A direct start on it is refused by design, so the bench first starts on a nonzero-match entry in table 1. That entry carries the table-swap and reset-timer bits, and it hands over to the match-0 self-branching entry in table 0. The bench then checks that a strobe appears on every cycle from that point on. The timing of the handover is counted cycle by cycle from the trigger edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int WORD_W    = 32;
  localparam int MATCH_LSB = 8;
  localparam int MATCH_W   = 14;
  localparam int CHAN_W    = 3;
  localparam int BR_LSB    = 6;
  localparam int THR_LSB   = 22;
  localparam int RST_BIT   = 24;
  localparam int UPD_BIT   = 31;

  typedef enum logic [1:0] {
    BR_NEXT  = 2'd0,
    BR_FIRST = 2'd1,
    BR_RSV2  = 2'd2,
    BR_RSV3  = 2'd3
  } branch_e;

  typedef struct packed {
    logic               upd;
    logic               rst_tmr;
    logic [1:0]         thr;
    logic [MATCH_W-1:0] match;
    branch_e            branch;
    logic [CHAN_W-1:0]  chan;
  } desc_t;

  function automatic desc_t decode(input logic [WORD_W-1:0] w);
    desc_t d;
    d.upd     = w[UPD_BIT];
    d.rst_tmr = w[RST_BIT];
    d.thr     = w[THR_LSB +: 2];
    d.match   = w[MATCH_LSB +: MATCH_W];
    d.branch  = branch_e'(w[BR_LSB +: 2]);
    d.chan    = w[CHAN_W-1:0];
    return d;
  endfunction
endpackage

// File: rtl/adc_seq_store.sv
module adc_seq_store
  import adc_seq_pkg::*;
#(
  parameter int ENTRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               wtab,
  input  logic [ENTRY_W-1:0] widx,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               ra_tab,
  input  logic [ENTRY_W-1:0] ra_idx,
  output logic [WORD_W-1:0]  ra_word,
  input  logic               rb_tab,
  input  logic [ENTRY_W-1:0] rb_idx,
  output logic [WORD_W-1:0]  rb_word
);
  localparam int SLOTS = 2 * (2 ** ENTRY_W);

  logic [WORD_W-1:0] mem_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[s] <= '0;
      end else if (we && ({wtab, widx} == (ENTRY_W+1)'(s))) begin
        mem_q[s] <= wdata;
      end
    end
  end

  assign ra_word = mem_q[{ra_tab, ra_idx}];
  assign rb_word = mem_q[{rb_tab, rb_idx}];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int TMR_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [TMR_W-1:0] tmr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (clr) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ENTRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic               sel_tab_in,
  input  logic [ENTRY_W-1:0] sel_idx_in,
  input  logic               err_clr,
  input  logic               sw_trig,
  input  logic [MATCH_W-1:0] tmr,
  input  logic [WORD_W-1:0]  cur_word,
  input  logic [WORD_W-1:0]  init_word,
  output logic               tmr_clr,
  output logic               sel_tab,
  output logic [ENTRY_W-1:0] sel_idx,
  output logic               run_q,
  output logic               tab_q,
  output logic [ENTRY_W-1:0] idx_q,
  output logic               err_q,
  output logic               conv_valid,
  output logic [CHAN_W-1:0]  conv_chan
);
  desc_t cur_d;
  desc_t init_d;
  logic  fire;
  logic  bad_branch;
  logic  bad_start;
  logic  err_set;
  logic  nxt_tab;
  logic [ENTRY_W-1:0] nxt_idx;

  always_comb begin
    cur_d      = decode(cur_word);
    init_d     = decode(init_word);
    fire       = run_q && (tmr == cur_d.match);
    bad_branch = (cur_d.branch == BR_RSV2) || (cur_d.branch == BR_RSV3);
    bad_start  = !run_q && sw_trig && (init_d.match == '0);
    err_set    = bad_start || (fire && bad_branch);
    tmr_clr    = !run_q || (fire && (cur_d.rst_tmr || bad_branch));
    nxt_tab    = cur_d.upd ? ~tab_q : tab_q;
    nxt_idx    = (cur_d.branch == BR_FIRST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_tab    <= 1'b0;
      sel_idx    <= '0;
      run_q      <= 1'b0;
      tab_q      <= 1'b0;
      idx_q      <= '0;
      err_q      <= 1'b0;
      conv_valid <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_valid <= 1'b0;
      if (err_set) begin
        err_q <= 1'b1;
      end else if (err_clr) begin
        err_q <= 1'b0;
      end
      if (!run_q) begin
        if (sel_we) begin
          sel_tab <= sel_tab_in;
          sel_idx <= sel_idx_in;
        end
        if (sw_trig && !bad_start) begin
          run_q <= 1'b1;
          tab_q <= sel_tab;
          idx_q <= sel_idx;
        end
      end else if (fire) begin
        conv_valid <= 1'b1;
        conv_chan  <= cur_d.chan;
        if (bad_branch) begin
          run_q <= 1'b0;
        end else begin
          tab_q <= nxt_tab;
          idx_q <= nxt_idx;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int ENTRY_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ENTRY_W+1:0]   cfg_addr,
  input  logic [31:0]          cfg_wdata,
  input  logic                 sw_trig,
  output logic                 conv_valid,
  output logic [2:0]           conv_chan,
  output logic                 run_active,
  output logic                 cur_table,
  output logic [ENTRY_W-1:0]   cur_index,
  output logic                 desc_err
);
  localparam int ADDR_W = ENTRY_W + 2;

  logic               desc_we;
  logic               sel_we;
  logic               err_clr;
  logic [MATCH_W-1:0] tmr_q;
  logic               tmr_clr;
  logic               sel_tab;
  logic [ENTRY_W-1:0] sel_idx;
  logic [WORD_W-1:0]  cur_word;
  logic [WORD_W-1:0]  init_word;

  always_comb begin
    desc_we = cfg_we && !cfg_addr[ADDR_W-1];
    sel_we  = cfg_we && cfg_addr[ADDR_W-1] && !cfg_addr[0];
    err_clr = cfg_we && cfg_addr[ADDR_W-1] && cfg_addr[0] && cfg_wdata[0];
  end

  adc_seq_store #(.ENTRY_W(ENTRY_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (desc_we),
    .wtab    (cfg_addr[ENTRY_W]),
    .widx    (cfg_addr[ENTRY_W-1:0]),
    .wdata   (cfg_wdata),
    .ra_tab  (cur_table),
    .ra_idx  (cur_index),
    .ra_word (cur_word),
    .rb_tab  (sel_tab),
    .rb_idx  (sel_idx),
    .rb_word (init_word)
  );

  adc_seq_timer #(.TMR_W(MATCH_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tmr   (tmr_q)
  );

  adc_seq_ctrl #(.ENTRY_W(ENTRY_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_we     (sel_we),
    .sel_tab_in (cfg_wdata[ENTRY_W]),
    .sel_idx_in (cfg_wdata[ENTRY_W-1:0]),
    .err_clr    (err_clr),
    .sw_trig    (sw_trig),
    .tmr        (tmr_q),
    .cur_word   (cur_word),
    .init_word  (init_word),
    .tmr_clr    (tmr_clr),
    .sel_tab    (sel_tab),
    .sel_idx    (sel_idx),
    .run_q      (run_active),
    .tab_q      (cur_table),
    .idx_q      (cur_index),
    .err_q      (desc_err),
    .conv_valid (conv_valid),
    .conv_chan  (conv_chan)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int ENTRY_W = 3,
  parameter int TMR_W   = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [ENTRY_W+1:0] cfg_addr,
  input logic [31:0]        cfg_wdata,
  input logic               conv_valid,
  input logic               run_active,
  input logic               desc_err,
  input logic [TMR_W-1:0]   tmr_q
);
  logic clr_wr;
  assign clr_wr = cfg_we && cfg_addr[ENTRY_W+1] && cfg_addr[0] && cfg_wdata[0];

  assert_idle_timer_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_active |-> (tmr_q == '0));

  assert_strobe_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> $past(run_active));

  assert_refused_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_err) |-> !run_active || $past(run_active));

  assert_stop_flags_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_active) |-> desc_err);

  assert_err_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(desc_err) |-> $past(clr_wr));
endmodule

bind adc_seq_top adc_seq_checker #(.ENTRY_W(ENTRY_W), .TMR_W(adc_seq_pkg::MATCH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .conv_valid (conv_valid),
  .run_active (run_active),
  .desc_err   (desc_err),
  .tmr_q      (tmr_q)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int EW = 3;
  localparam int WIN = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [EW+1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          sw_trig = 1'b0;
  logic          conv_valid;
  logic [2:0]    conv_chan;
  logic          run_active;
  logic          cur_table;
  logic [EW-1:0] cur_index;
  logic          desc_err;

  int total = 0;
  int bad = 0;
  logic vld [0:WIN];
  int   chn [0:WIN];

  always #4 clk = ~clk;

  adc_seq_top #(.ENTRY_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sw_trig(sw_trig), .conv_valid(conv_valid),
    .conv_chan(conv_chan), .run_active(run_active), .cur_table(cur_table),
    .cur_index(cur_index), .desc_err(desc_err)
  );

  function automatic logic [31:0] mk(input bit upd, input int thr, input bit rst,
                                     input int match, input int br, input int ch);
    return {upd, 6'b0, rst, 2'(thr), 14'(match), 2'(br), 3'b0, 3'(ch)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = (EW+2)'(addr);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_start(input int tab, input int idx);
    wr(16, 32'((tab << EW) | idx));
  endtask

  // Pulse trigger, then record outputs for k = 0..n after the start edge.
  task automatic run_win(input int n);
    @(negedge clk);
    sw_trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sw_trig = 1'b0;
    vld[0] = conv_valid;
    chn[0] = int'(conv_chan);
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      vld[k] = conv_valid;
      chn[k] = int'(conv_chan);
    end
  endtask

  task automatic expect_strobe(input string req, input int k, input bit v, input int ch);
    chk(vld[k] == v, req, int'(vld[k]), int'(v));
    if (v) chk(chn[k] == ch, req, chn[k], ch);
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk(!run_active, "R1 run after reset", int'(run_active), 0);
    chk(!conv_valid, "R1 strobe after reset", int'(conv_valid), 0);
    chk(!desc_err, "R1 err after reset", int'(desc_err), 0);
    wr(0, mk(0, 0, 1, 0, 1, 1));
    wr(1, mk(0, 0, 1, 1, 1, 1));
    set_start(0, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!conv_valid && !run_active, "R1 idle without trigger", int'(conv_valid), 0);
    end
  endtask

  task automatic t_basic_loop();
    do_reset();
    wr(0, mk(0, 0, 1, 3, 0, 2));
    wr(1, mk(0, 0, 1, 2, 1, 5));
    set_start(0, 0);
    run_win(12);
    for (int k = 1; k <= 12; k++) begin
      if (k == 4 || k == 11) expect_strobe("R2 R4 basic", k, 1'b1, 2);
      else if (k == 7) expect_strobe("R2 R4 basic", k, 1'b1, 5);
      else expect_strobe("R2 basic quiet", k, 1'b0, 0);
    end
    chk(run_active, "R2 still running", int'(run_active), 1);
  endtask

  task automatic t_no_reset();
    do_reset();
    wr(0, mk(0, 0, 0, 3, 0, 2));
    wr(1, mk(0, 0, 1, 8, 1, 5));
    set_start(0, 0);
    run_win(14);
    for (int k = 1; k <= 14; k++) begin
      if (k == 4 || k == 13) expect_strobe("R3 timer continues", k, 1'b1, 2);
      else if (k == 9) expect_strobe("R3 timer continues", k, 1'b1, 5);
      else expect_strobe("R3 quiet", k, 1'b0, 0);
    end
  endtask

  task automatic t_full_rate();
    do_reset();
    wr(8 + 2, mk(1, 0, 1, 4, 1, 6));
    wr(0, mk(0, 0, 1, 0, 1, 3));
    set_start(1, 2);
    run_win(20);
    for (int k = 1; k <= 4; k++) expect_strobe("R5 lead-in quiet", k, 1'b0, 0);
    expect_strobe("R5 swap entry", 5, 1'b1, 6);
    for (int k = 6; k <= 20; k++) expect_strobe("R6 every cycle", k, 1'b1, 3);
    chk(cur_table == 1'b0, "R5 R11 table after swap", int'(cur_table), 0);
    chk(cur_index == '0, "R11 index in loop", int'(cur_index), 0);
    chk(!desc_err, "R6 no error", int'(desc_err), 0);
  endtask

  task automatic t_bad_start();
    do_reset();
    wr(0, mk(0, 0, 1, 0, 1, 1));
    set_start(0, 0);
    run_win(8);
    chk(desc_err, "R7 err on match-0 start", int'(desc_err), 1);
    chk(!run_active, "R7 not started", int'(run_active), 0);
    for (int k = 1; k <= 8; k++) expect_strobe("R7 no strobe", k, 1'b0, 0);
    wr(17, 32'h0);
    chk(desc_err, "R9 write 0 keeps err", int'(desc_err), 1);
    wr(17, 32'h1);
    chk(!desc_err, "R9 write 1 clears err", int'(desc_err), 0);
  endtask

  task automatic t_bad_branch();
    do_reset();
    wr(0, mk(0, 0, 1, 2, 2, 4));
    set_start(0, 0);
    run_win(10);
    expect_strobe("R8 strobe still issued", 3, 1'b1, 4);
    chk(desc_err, "R8 err set", int'(desc_err), 1);
    chk(!run_active, "R8 stopped", int'(run_active), 0);
    for (int k = 4; k <= 10; k++) expect_strobe("R8 no more strobes", k, 1'b0, 0);
  endtask

  task automatic t_wrap_thresh();
    do_reset();
    wr(7, mk(0, 2, 1, 1, 0, 7));
    wr(0, mk(0, 3, 1, 1, 1, 1));
    set_start(0, 7);
    chk(!run_active, "R12 start select while idle", int'(run_active), 0);
    run_win(8);
    chk(cur_index == '0, "R4 R11 index wrapped", int'(cur_index), 0);
    expect_strobe("R4 R10 entry 7", 2, 1'b1, 7);
    expect_strobe("R4 R10 entry 0", 4, 1'b1, 1);
    expect_strobe("R10 entry 0 again", 6, 1'b1, 1);
    expect_strobe("R10 quiet", 3, 1'b0, 0);
    expect_strobe("R10 quiet", 5, 1'b0, 0);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_basic_loop();
    t_no_reset();
    t_full_rate();
    t_bad_start();
    t_bad_branch();
    t_wrap_thresh();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule